// File: doc/BRIEF.md
# Stereo Voice Sample FIFO Front End

This block sits between a host and the playback and recording core of a voice codec. It holds two 16-bit sample queues, one for the left channel and one for the right, each 32 words deep. A microcontroller reaches the block through a strobed port with chip select, read, write and data/command strobes. When the data/command line is low, the port writes a control byte or reads a status byte on the low eight bits. When that line is high, the port moves whole 16-bit samples. A DMA controller can also feed or drain the queues through request and acknowledge pairs with its own read and write strobes.

Three flag pins report empty, more-than-half and full for one queue at a time. In stereo mode a channel-select input picks which queue the pins show. In mono mode the pins always show the left queue. The control byte can invert the active level of the flags, of the DMA requests and of the DMA acknowledges.

A small state machine runs the session. Its states are ST_IDLE, ST_PREFILL (play was commanded and the queues are filling), ST_STREAM (samples are consumed, one per `sample_tick`), ST_HOLD (paused) and ST_CAPTURE (recording, with samples pushed from `rec_sample`).
- ST_IDLE goes to ST_PREFILL on play, to ST_CAPTURE on record and to ST_HOLD on pause.
- ST_PREFILL goes to ST_STREAM once the played queues first pass half occupancy. Another mode sends it to the matching state.
- ST_STREAM leaves on idle, record or pause.
- ST_HOLD returns on play. It goes to ST_STREAM if streaming had already begun, otherwise to ST_PREFILL. Idle and record move it to ST_IDLE and ST_CAPTURE.
- ST_CAPTURE leaves on idle, play or pause.

Top module: `stereo_voice_fifo`

## Requirements
- R1: Strobe timing and chip select. A read or write strobe acts on the clock edge at which it is first seen low. Host `rd_n`/`wr_n` strobes take effect only when `cs_n` is low at that edge; with `cs_n` high they change neither the queues nor the control byte.
- R2: Command and status access (`dc`=0). A write loads the control byte from `data_in[7:0]`:
  - bits [1:0] select the mode: 00 idle, 01 play, 10 record, 11 pause;
  - bit 2 selects stereo;
  - bit 3 enables DMA;
  - bits 4, 5 and 6 invert the flag pins, the DMA request pins and the DMA acknowledge pins.

  A status read returns {12'b0, busy, full, half, empty} for the displayed queue on `bus_out`. These four bits are active high and are not inverted by bit 4.
- R3: Queue flags and overflow. Empty means 0 words, half means 17 or more words, and full means 32 words. Writes to a full queue are dropped. Empty and full are never both true.
- R4: Playback start and consumption. Consumption starts only after the left queue (mono), or both queues (stereo), first reach half. After that, each `sample_tick` pops one word from each played queue, provided every played queue holds data. The popped words appear on `play_left`/`play_right` with `play_valid` high in the next cycle. `play_right` is 0 in mono.
- R5: Channel display and routing. In stereo, `ch_sel`=1 shows the right queue on the flag pins and sends host sample accesses to the right queue; `ch_sel`=0 uses the left queue. In mono, the left queue is always used.
- R6: DMA requests. With DMA enabled during ST_PREFILL or ST_STREAM, the left request is active while the left queue is not full, and the right request is active (stereo only) while the right queue is not full. In ST_CAPTURE, the left request is active while the left queue holds data. Requests are inactive otherwise.
- R7: DMA strobes. `iow_n` pushes `data_in` and `ior_n` pops onto `bus_out`. A strobe is honoured only with DMA enabled and while the matching acknowledge is at its active level, which is low by default. The right pair works only in stereo.
- R8: Polarity control. Control bit 4 inverts the three flag pins, bit 5 inverts both request pins, and bit 6 makes the acknowledges active high.
- R9: Busy indication. `busy_n` is low in every state except ST_IDLE.
- R10: Reset. Reset empties both queues, clears the control byte (mono, idle, default polarities), sets the state to ST_IDLE and clears `bus_out`.
- R11: Pause. Pause stops consumption and keeps the queue contents. Play after pause resumes streaming at once if streaming had begun.
- R12: Recording and reads. In ST_CAPTURE, `rec_push` stores `rec_sample` into the left queue. A host data read or a DMA read pops the oldest word onto `bus_out`, and a read from an empty queue returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| dc | input | 1 | 1 = sample data, 0 = command/status |
| ch_sel | input | 1 | Stereo channel select for flags and host sample access |
| data_in | input | 16 | Write data for host and DMA |
| bus_out | output | 16 | Read data / status |
| iow_n | input | 1 | DMA write strobe, active low |
| ior_n | input | 1 | DMA read strobe, active low |
| dack_l | input | 1 | Left DMA acknowledge |
| dack_r | input | 1 | Right DMA acknowledge |
| dreq_l | output | 1 | Left DMA request |
| dreq_r | output | 1 | Right DMA request |
| flag_empty | output | 1 | Displayed queue empty |
| flag_half | output | 1 | Displayed queue above half |
| flag_full | output | 1 | Displayed queue full |
| busy_n | output | 1 | Low while a session is active |
| rec_push | input | 1 | Record sample strobe |
| rec_sample | input | 16 | Record sample value |
| sample_tick | input | 1 | Playback sample rate tick |
| play_valid | output | 1 | Played sample valid |
| play_left | output | 16 | Played left sample |
| play_right | output | 16 | Played right sample |

## Verification
A wrong occupancy count shows on the flag pins in the cycle after the offending strobe. A dropped or extra word shows as a misordered value on `bus_out` or `play_left` when the queue is drained. A wrong state appears at `busy_n` and the request pins one cycle after the control byte is written. Streaming that starts too early shows as `play_valid` after a tick with 16 words queued, and a lost resume shows as a missing sample on the first tick after play returns from pause. A polarity bit that is misapplied inverts a pin at once, or stops DMA strobes from being honoured, which the half flag then reveals.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int NCH   = 2;
    localparam int CMD_W = 7;

    typedef enum logic [1:0] {
        MD_IDLE  = 2'd0,
        MD_PLAY  = 2'd1,
        MD_REC   = 2'd2,
        MD_PAUSE = 2'd3
    } sfe_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREFILL,
        ST_STREAM,
        ST_HOLD,
        ST_CAPTURE
    } sfe_state_e;

    typedef struct packed {
        logic      inv_dack;
        logic      inv_dreq;
        logic      inv_flag;
        logic      dma_en;
        logic      stereo;
        sfe_mode_e mode;
    } sfe_cmd_t;

endpackage

// File: rtl/sfe_fifo.sv
module sfe_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic                         pop_i,
    input  logic [DW-1:0]                din_i,
    output logic [DW-1:0]                head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         empty_o,
    output logic                         half_o,
    output logic                         full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          push_ok, pop_ok;

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CW'(DEPTH));
    assign half_o  = (count_q > CW'(DEPTH / 2));
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;
    assign head_o  = mem[rd_ptr_q];
    assign count_o = count_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr_q] <= din_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= bump(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= bump(rd_ptr_q);
            unique case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH)); // R3
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !pop_i) |=> full_o); // R3

endmodule

// File: rtl/sfe_host_port.sv
module sfe_host_port
    import sfe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 dc,
    input  logic                 ch_sel,
    input  logic                 iow_n,
    input  logic                 ior_n,
    input  logic                 dack_l,
    input  logic                 dack_r,
    input  logic [CMD_W-1:0]     cmd_byte,
    output sfe_cmd_t             cmd_o,
    output logic [NCH-1:0]       push_o,
    output logic [NCH-1:0]       pop_o,
    output logic                 stat_rd_o,
    output logic                 data_rd_o,
    output logic                 rd_ch_o
);
    sfe_cmd_t cmd_q;
    logic prev_rd_q, prev_wr_q, prev_iow_q, prev_ior_q;
    logic rd_fall, wr_fall, iow_fall, ior_fall;
    logic host_wr, host_rd, host_sel;
    logic [NCH-1:0] dack_act, dma_ch_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_rd_q  <= 1'b1;
            prev_wr_q  <= 1'b1;
            prev_iow_q <= 1'b1;
            prev_ior_q <= 1'b1;
            cmd_q      <= '0;
        end else begin
            prev_rd_q  <= rd_n;
            prev_wr_q  <= wr_n;
            prev_iow_q <= iow_n;
            prev_ior_q <= ior_n;
            if (host_wr && !dc) begin
                cmd_q <= sfe_cmd_t'(cmd_byte);
            end
        end
    end

    assign rd_fall  = prev_rd_q  && !rd_n;
    assign wr_fall  = prev_wr_q  && !wr_n;
    assign iow_fall = prev_iow_q && !iow_n;
    assign ior_fall = prev_ior_q && !ior_n;

    assign host_wr  = !cs_n && wr_fall;
    assign host_rd  = !cs_n && rd_fall;
    assign host_sel = cmd_q.stereo && ch_sel;

    assign dack_act[0]  = (dack_l == cmd_q.inv_dack);
    assign dack_act[1]  = (dack_r == cmd_q.inv_dack);
    assign dma_ch_ok[0] = cmd_q.dma_en && dack_act[0];
    assign dma_ch_ok[1] = cmd_q.dma_en && dack_act[1] && cmd_q.stereo;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign push_o[c] = (host_wr && dc && (host_sel == c[0]))
                         || (iow_fall && dma_ch_ok[c]);
        assign pop_o[c]  = (host_rd && dc && (host_sel == c[0]))
                         || (ior_fall && dma_ch_ok[c]);
    end

    always_comb begin
        if (ior_fall && dma_ch_ok[0]) begin
            rd_ch_o = 1'b0;
        end else if (ior_fall && dma_ch_ok[1]) begin
            rd_ch_o = 1'b1;
        end else begin
            rd_ch_o = host_sel;
        end
    end

    assign stat_rd_o = host_rd && !dc;
    assign data_rd_o = |pop_o;
    assign cmd_o     = cmd_q;

    AST_CS_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(cmd_q)); // R1

endmodule

// File: rtl/sfe_play_fsm.sv
module sfe_play_fsm
    import sfe_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  sfe_mode_e       mode_i,
    input  logic            stereo_i,
    input  logic            half_l_i,
    input  logic            half_r_i,
    input  logic            empty_l_i,
    input  logic            empty_r_i,
    input  logic            tick_i,
    input  logic [DW-1:0]   head_l_i,
    input  logic [DW-1:0]   head_r_i,
    output sfe_state_e      state_o,
    output logic            busy_o,
    output logic            playing_o,
    output logic [NCH-1:0]  pop_o,
    output logic            valid_o,
    output logic [DW-1:0]   left_o,
    output logic [DW-1:0]   right_o
);
    sfe_state_e state_q, state_d;
    logic       started_q, started_d;
    logic       half_ok, avail, consume;

    assign half_ok = stereo_i ? (half_l_i && half_r_i) : half_l_i;
    assign avail   = stereo_i ? (!empty_l_i && !empty_r_i) : !empty_l_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            started_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            started_q <= started_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        started_d = started_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (mode_i)
                    MD_PLAY:  state_d = ST_PREFILL;
                    MD_REC:   state_d = ST_CAPTURE;
                    MD_PAUSE: state_d = ST_HOLD;
                    default:  state_d = ST_IDLE;
                endcase
            end
            ST_PREFILL: begin
                unique case (mode_i)
                    MD_IDLE:  state_d = ST_IDLE;
                    MD_REC:   state_d = ST_CAPTURE;
                    MD_PAUSE: state_d = ST_HOLD;
                    default:  state_d = half_ok ? ST_STREAM : ST_PREFILL;
                endcase
            end
            ST_STREAM: begin
                unique case (mode_i)
                    MD_IDLE:  state_d = ST_IDLE;
                    MD_REC:   state_d = ST_CAPTURE;
                    MD_PAUSE: state_d = ST_HOLD;
                    default:  state_d = ST_STREAM;
                endcase
            end
            ST_HOLD: begin
                unique case (mode_i)
                    MD_IDLE:  state_d = ST_IDLE;
                    MD_REC:   state_d = ST_CAPTURE;
                    MD_PLAY:  state_d = started_q ? ST_STREAM : ST_PREFILL;
                    default:  state_d = ST_HOLD;
                endcase
            end
            ST_CAPTURE: begin
                unique case (mode_i)
                    MD_IDLE:  state_d = ST_IDLE;
                    MD_PLAY:  state_d = ST_PREFILL;
                    MD_PAUSE: state_d = ST_HOLD;
                    default:  state_d = ST_CAPTURE;
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
        if (state_d == ST_STREAM) begin
            started_d = 1'b1;
        end else if (state_d == ST_IDLE || state_d == ST_CAPTURE) begin
            started_d = 1'b0;
        end
    end

    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        playing_o = (state_q == ST_PREFILL) || (state_q == ST_STREAM);
        consume   = (state_q == ST_STREAM) && tick_i && avail;
        pop_o[0]  = consume;
        pop_o[1]  = consume && stereo_i;
        state_o   = state_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            left_o  <= '0;
            right_o <= '0;
        end else begin
            valid_o <= consume;
            if (consume) begin
                left_o  <= head_l_i;
                right_o <= stereo_i ? head_r_i : '0;
            end
        end
    end

    AST_STREAM_AFTER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM && $past(state_q) == ST_PREFILL) |-> $past(half_ok)); // R4
    AST_VALID_FROM_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(state_q == ST_STREAM)); // R4

endmodule

// File: rtl/stereo_voice_fifo.sv
module stereo_voice_fifo
    import sfe_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          dc,
    input  logic          ch_sel,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] bus_out,
    input  logic          iow_n,
    input  logic          ior_n,
    input  logic          dack_l,
    input  logic          dack_r,
    output logic          dreq_l,
    output logic          dreq_r,
    output logic          flag_empty,
    output logic          flag_half,
    output logic          flag_full,
    output logic          busy_n,
    input  logic          rec_push,
    input  logic [DW-1:0] rec_sample,
    input  logic          sample_tick,
    output logic          play_valid,
    output logic [DW-1:0] play_left,
    output logic [DW-1:0] play_right
);
    localparam int CW = $clog2(DEPTH+1);

    sfe_cmd_t       cmd;
    sfe_state_e     state;
    logic [NCH-1:0] port_push, port_pop, play_pop, q_push, q_pop;
    logic [NCH-1:0] q_empty, q_half, q_full;
    logic [DW-1:0]  q_head [NCH];
    logic [DW-1:0]  q_din  [NCH];
    logic [CW-1:0]  q_count [NCH];
    logic           stat_rd, data_rd, rd_ch, busy, playing, rec_ok, disp;
    logic           sel_empty, sel_half, sel_full;

    sfe_host_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .dc        (dc),
        .ch_sel    (ch_sel),
        .iow_n     (iow_n),
        .ior_n     (ior_n),
        .dack_l    (dack_l),
        .dack_r    (dack_r),
        .cmd_byte  (data_in[CMD_W-1:0]),
        .cmd_o     (cmd),
        .push_o    (port_push),
        .pop_o     (port_pop),
        .stat_rd_o (stat_rd),
        .data_rd_o (data_rd),
        .rd_ch_o   (rd_ch)
    );

    assign rec_ok = rec_push && (state == ST_CAPTURE);

    for (genvar c = 0; c < NCH; c++) begin : g_q
        if (c == 0) begin : g_rec
            assign q_push[c] = port_push[c] || rec_ok;
            assign q_din[c]  = rec_ok ? rec_sample : data_in;
        end else begin : g_norec
            assign q_push[c] = port_push[c];
            assign q_din[c]  = data_in;
        end
        assign q_pop[c] = port_pop[c] || play_pop[c];

        sfe_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (q_push[c]),
            .pop_i   (q_pop[c]),
            .din_i   (q_din[c]),
            .head_o  (q_head[c]),
            .count_o (q_count[c]),
            .empty_o (q_empty[c]),
            .half_o  (q_half[c]),
            .full_o  (q_full[c])
        );
    end

    sfe_play_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (cmd.mode),
        .stereo_i  (cmd.stereo),
        .half_l_i  (q_half[0]),
        .half_r_i  (q_half[1]),
        .empty_l_i (q_empty[0]),
        .empty_r_i (q_empty[1]),
        .tick_i    (sample_tick),
        .head_l_i  (q_head[0]),
        .head_r_i  (q_head[1]),
        .state_o   (state),
        .busy_o    (busy),
        .playing_o (playing),
        .pop_o     (play_pop),
        .valid_o   (play_valid),
        .left_o    (play_left),
        .right_o   (play_right)
    );

    assign disp      = cmd.stereo && ch_sel;
    assign sel_empty = q_empty[disp];
    assign sel_half  = q_half[disp];
    assign sel_full  = q_full[disp];

    assign flag_empty = sel_empty ^ cmd.inv_flag;
    assign flag_half  = sel_half  ^ cmd.inv_flag;
    assign flag_full  = sel_full  ^ cmd.inv_flag;
    assign busy_n     = !busy;

    assign dreq_l = (cmd.dma_en && ((playing && !q_full[0])
                  || (state == ST_CAPTURE && !q_empty[0]))) ^ cmd.inv_dreq;
    assign dreq_r = (cmd.dma_en && cmd.stereo && playing && !q_full[1])
                  ^ cmd.inv_dreq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_out <= '0;
        end else if (stat_rd) begin
            bus_out <= DW'({busy, sel_full, sel_half, sel_empty});
        end else if (data_rd) begin
            bus_out <= q_empty[rd_ch] ? '0 : q_head[rd_ch];
        end
    end

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_empty && sel_full)); // R3
    AST_BUSY_WHILE_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
        play_valid |-> $past(!busy_n)); // R9
    AST_COUNT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push[0] && !q_pop[0] && !q_full[0]) |=> (q_count[0] == $past(q_count[0]) + 1'b1)); // R3

endmodule

// File: tb/stereo_voice_fifo_test.sv
module stereo_voice_fifo_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, dc = 1'b0, ch_sel = 1'b0;
    logic [15:0] data_in = '0;
    logic [15:0] bus_out;
    logic iow_n = 1'b1, ior_n = 1'b1, dack_l = 1'b1, dack_r = 1'b1;
    logic dreq_l, dreq_r, flag_empty, flag_half, flag_full, busy_n;
    logic rec_push = 1'b0;
    logic [15:0] rec_sample = '0;
    logic sample_tick = 1'b0;
    logic play_valid;
    logic [15:0] play_left, play_right;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    stereo_voice_fifo uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .dc(dc), .ch_sel(ch_sel), .data_in(data_in), .bus_out(bus_out),
        .iow_n(iow_n), .ior_n(ior_n), .dack_l(dack_l), .dack_r(dack_r),
        .dreq_l(dreq_l), .dreq_r(dreq_r), .flag_empty(flag_empty),
        .flag_half(flag_half), .flag_full(flag_full), .busy_n(busy_n),
        .rec_push(rec_push), .rec_sample(rec_sample), .sample_tick(sample_tick),
        .play_valid(play_valid), .play_left(play_left), .play_right(play_right)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_wr(input logic sel_cs, input logic d_c, input logic [15:0] v);
        @(negedge clk);
        cs_n = !sel_cs; dc = d_c; data_in = v; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic host_rd(input logic d_c);
        @(negedge clk);
        cs_n = 1'b0; dc = d_c; rd_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic dma_wr(input logic [15:0] v);
        @(negedge clk);
        data_in = v; iow_n = 1'b0;
        @(negedge clk);
        iow_n = 1'b1;
    endtask

    task automatic dma_rd();
        @(negedge clk);
        ior_n = 1'b0;
        @(negedge clk);
        ior_n = 1'b1;
    endtask

    task automatic tick();
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);
        host_wr(1'b1, 1'b0, {8'h00, b});
        cyc();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        // R10 reset state
        chk("R10 empty after reset", 16'(flag_empty), 16'd1);
        chk("R10 half after reset", 16'(flag_half), 16'd0);
        chk("R10 full after reset", 16'(flag_full), 16'd0);
        chk("R10 busy_n after reset", 16'(busy_n), 16'd1);
        chk("R10 dreq_l after reset", 16'(dreq_l), 16'd0);
        chk("R10 bus_out after reset", bus_out, 16'h0000);
        // R2 status read
        host_rd(1'b0);
        chk("R2 status idle empty", bus_out, 16'h0001);
        // R1 writes with cs_n high are ignored
        host_wr(1'b0, 1'b1, 16'hDEAD);
        host_wr(1'b0, 1'b0, 16'h0001);
        cyc();
        chk("R1 cs high no push", 16'(flag_empty), 16'd1);
        chk("R1 cs high no command", 16'(busy_n), 16'd1);
        // R3 sweep of occupancy 1..34 writes
        for (int i = 0; i < 34; i++) begin
            int n;
            host_wr(1'b1, 1'b1, 16'h0100 + 16'(3 * i));
            n = (i + 1 > 32) ? 32 : i + 1;
            chk("R3 empty flag", 16'(flag_empty), 16'(n == 0));
            chk("R3 half flag", 16'(flag_half), 16'(n >= 17));
            chk("R3 full flag", 16'(flag_full), 16'(n == 32));
        end
        // R12 reads drain in order, overflowed words dropped
        for (int i = 0; i < 32; i++) begin
            int n;
            host_rd(1'b1);
            n = 31 - i;
            chk("R12 read order", bus_out, 16'h0100 + 16'(3 * i));
            chk("R3 half while draining", 16'(flag_half), 16'(n >= 17));
        end
        chk("R3 empty after drain", 16'(flag_empty), 16'd1);
        host_rd(1'b1);
        chk("R12 empty read gives zero", bus_out, 16'h0000);
        // R9 R6 play mono with DMA
        cmd(8'h09);
        chk("R9 busy in play", 16'(busy_n), 16'd0);
        chk("R6 dreq_l play not full", 16'(dreq_l), 16'd1);
        chk("R6 dreq_r mono", 16'(dreq_r), 16'd0);
        // R7 inactive dack ignored
        dack_l = 1'b1;
        dma_wr(16'hBEEF);
        chk("R7 dack inactive no push", 16'(flag_empty), 16'd1);
        dack_l = 1'b0;
        for (int i = 0; i < 16; i++) dma_wr(16'h5000 + 16'(i));
        chk("R7 dma pushes 16", 16'(flag_half), 16'd0);
        tick();
        chk("R4 no playback below half", 16'(play_valid), 16'd0);
        dma_wr(16'h5010);
        chk("R4 half reached", 16'(flag_half), 16'd1);
        ch_sel = 1'b1;
        #1;
        chk("R5 mono ignores ch_sel", 16'(flag_empty), 16'd0);
        ch_sel = 1'b0;
        cyc();
        tick();
        chk("R4 playback valid", 16'(play_valid), 16'd1);
        chk("R4 first sample", play_left, 16'h5000);
        chk("R4 right zero in mono", play_right, 16'h0000);
        // R11 pause and resume
        cmd(8'h0B);
        tick();
        chk("R11 no playback in pause", 16'(play_valid), 16'd0);
        chk("R9 busy in pause", 16'(busy_n), 16'd0);
        cmd(8'h09);
        tick();
        chk("R11 resume at once", 16'(play_valid), 16'd1);
        chk("R11 resume sample", play_left, 16'h5001);
        // R8 polarity inversion, 15 words queued
        cmd(8'h19);
        chk("R8 empty inverted", 16'(flag_empty), 16'd1);
        chk("R8 half inverted", 16'(flag_half), 16'd1);
        chk("R8 full inverted", 16'(flag_full), 16'd1);
        cmd(8'h29);
        chk("R8 dreq inverted", 16'(dreq_l), 16'd0);
        cmd(8'h49);
        dack_l = 1'b0;
        dma_wr(16'h6000);
        dma_wr(16'h6001);
        chk("R8 dack low now inactive", 16'(flag_half), 16'd0);
        dack_l = 1'b1;
        dma_wr(16'h6002);
        dma_wr(16'h6003);
        chk("R8 dack high now active", 16'(flag_half), 16'd1);
        dack_l = 1'b1;
        // R5 stereo flag routing
        cmd(8'h05);
        dack_l = 1'b1;
        ch_sel = 1'b1;
        #1;
        chk("R5 right shown empty", 16'(flag_empty), 16'd1);
        ch_sel = 1'b0;
        #1;
        chk("R5 left shown", 16'(flag_empty), 16'd0);
        chk("R5 left half", 16'(flag_half), 16'd1);
        ch_sel = 1'b1;
        host_wr(1'b1, 1'b1, 16'h7777);
        chk("R5 host write to right", 16'(flag_empty), 16'd0);
        ch_sel = 1'b0;
        cmd(8'h0D);
        chk("R6 dreq_r stereo", 16'(dreq_r), 16'd1);
        chk("R6 dreq_l stereo", 16'(dreq_l), 16'd1);
        // R10 reset mid-session
        do_reset();
        chk("R10 queues cleared", 16'(flag_empty), 16'd1);
        chk("R10 busy cleared", 16'(busy_n), 16'd1);
        chk("R10 polarity default", 16'(dreq_l), 16'd0);
        // R12 recording
        cmd(8'h0A);
        chk("R6 dreq_l record empty", 16'(dreq_l), 16'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rec_push = 1'b1;
            rec_sample = 16'hA000 + 16'(i);
        end
        @(negedge clk);
        rec_push = 1'b0;
        chk("R6 dreq_l record data", 16'(dreq_l), 16'd1);
        dack_l = 1'b0;
        dma_rd();
        chk("R12 dma read", bus_out, 16'hA000);
        dack_l = 1'b1;
        host_rd(1'b1);
        chk("R12 host read", bus_out, 16'hA001);
        host_rd(1'b0);
        chk("R2 status busy", bus_out, 16'h0008);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule